// File: doc/BRIEF.md
# Snooping Translation Buffer

This block is a small, fully associative translation buffer for one processor. It maps a virtual page number plus an address-space identifier to a physical page number and a permission field. The lookup is combinational, so a request and its answer fall in the same cycle. A refill port writes one translation per cycle from the page walker.

Several processors can hold the same page table entry at once. When system software swaps a page out or changes its permissions, it broadcasts an invalidate command on a shared bus. The command carries the virtual page number and the address-space identifier. Every buffer on the bus watches that bus, including the one in the issuing processor.

Each buffer compares the command against all of its entries in parallel. A matching entry is dropped in a single cycle. A command that matches nothing changes nothing. After every command the buffer pulses a completion strobe for exactly one cycle, so the bus side can count how many buffers have finished.

Top module: `snoop_tlb`

## Requirements
- R1: After reset, every entry is invalid. `lk_hit` is 0 for any lookup and `snp_done` is 0.
- R2: While `lk_vld` is 1 and a valid entry holds the same `{lk_asid, lk_vpn}`, `lk_hit` is 1 in that same cycle and `lk_ppn`/`lk_perm` return the stored values. Otherwise `lk_hit` is 0 and `lk_ppn`/`lk_perm` are 0.
- R3: A lookup hits only when the address-space identifier also matches. The same page number under another identifier misses.
- R4: A refill (`fill_vld` = 1) is visible to lookups from the cycle after its clock edge. When any entry is invalid, the refill goes into an invalid entry and evicts nothing.
- R5: A refill whose key is already held overwrites that entry in place. It takes no new slot, so there are never two entries with one key, and it does not move the replacement pointer.
- R6: When all 16 entries are valid, a refill of a new key replaces the entry under a round-robin pointer. The pointer starts at entry 0 after reset and advances by one per such replacement. Entries are filled in index order from 0, so the Nth eviction after 16 fills from reset removes the Nth key filled.
- R7: A snoop (`snp_vld` = 1) whose `{snp_asid, snp_vpn}` matches a valid entry invalidates it. From the next cycle, lookups of that key miss, and all other entries are unaffected.
- R8: A snoop that matches no entry changes no stored translation.
- R9: `snp_done` is 1 for exactly the one cycle after each cycle with `snp_vld` = 1, whether the snoop hit or missed. Back-to-back snoops give back-to-back pulses.
- R10: If a refill and a snoop carry the same key in the same cycle, the snoop wins: that key misses from the next cycle.
- R11: A lookup in the same cycle as a snoop of the same key reports a miss in that cycle. Lookups of other keys are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vld | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_hit | output | 1 | Lookup found a live translation |
| lk_ppn | output | 20 | Physical page number on hit, else 0 |
| lk_perm | output | 4 | Permission field on hit, else 0 |
| fill_vld | input | 1 | Refill write strobe |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_asid | input | 8 | Refill address-space identifier |
| fill_ppn | input | 20 | Refill physical page number |
| fill_perm | input | 4 | Refill permission field |
| snp_vld | input | 1 | Invalidate command seen on the bus |
| snp_vpn | input | 20 | Invalidate virtual page number |
| snp_asid | input | 8 | Invalidate address-space identifier |
| snp_done | output | 1 | One-cycle completion pulse per invalidate command |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions: a bus invalidate landing on the very edge where a refill of that key is written, or during the cycle a lookup of that key is being answered. The bench drives all inputs together at one falling edge to line these up exactly. It then reads the combinational lookup before the next rising edge and again after it. Round-robin eviction is reached by filling all sixteen entries from reset with known keys and then refilling. In-place updates are mixed in between evictions, to show that they leave the pointer where it was.

// File: rtl/stlb_pkg.sv
package stlb_pkg;
  localparam int DEF_ENTRIES = 16;
  localparam int DEF_VPN_W   = 20;
  localparam int DEF_ASID_W  = 8;
  localparam int DEF_PPN_W   = 20;
  localparam int DEF_PERM_W  = 4;

  // how a refill picks its slot
  typedef enum logic [1:0] {
    FILL_NONE   = 2'd0,
    FILL_UPDATE = 2'd1,
    FILL_FREE   = 2'd2,
    FILL_EVICT  = 2'd3
  } fill_kind_e;
endpackage

// File: rtl/stlb_match.sv
// Parallel key comparator: one equality per entry, gated by that entry's valid bit.
module stlb_match #(
  parameter int N     = 16,
  parameter int KEY_W = 28
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][KEY_W-1:0] keys,
  input  logic [KEY_W-1:0]        probe,
  output logic [N-1:0]            hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = valid[g] && (keys[g] == probe);
  end
endmodule

// File: rtl/stlb_victim.sv
// Slot choice for a refill: existing key, else lowest free entry, else round-robin.
module stlb_victim
  import stlb_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fill_go,
  input  logic [N-1:0]         valid,
  input  logic [N-1:0]         same_key,
  output logic [$clog2(N)-1:0] slot,
  output fill_kind_e           kind
);
  localparam int IDX_W = $clog2(N);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] rr_q;

  function automatic logic [IDX_W-1:0] lowest_set(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    kind = FILL_NONE;
    slot = rr_q;
    if (fill_go) begin
      if (|same_key) begin
        kind = FILL_UPDATE;
        slot = lowest_set(same_key);
      end else if (!(&valid)) begin
        kind = FILL_FREE;
        slot = lowest_set(~valid);
      end else begin
        kind = FILL_EVICT;
        slot = rr_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (kind == FILL_EVICT) begin
      rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/snoop_tlb.sv
module snoop_tlb
  import stlb_pkg::*;
#(
  parameter int N_ENTRIES = DEF_ENTRIES,
  parameter int VPN_W     = DEF_VPN_W,
  parameter int ASID_W    = DEF_ASID_W,
  parameter int PPN_W     = DEF_PPN_W,
  parameter int PERM_W    = DEF_PERM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_vld,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              fill_vld,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              snp_vld,
  input  logic [VPN_W-1:0]  snp_vpn,
  input  logic [ASID_W-1:0] snp_asid,
  output logic              snp_done
);
  localparam int KEY_W = VPN_W + ASID_W;
  localparam int IDX_W = $clog2(N_ENTRIES);

  // storage
  logic [N_ENTRIES-1:0]             valid_q;
  logic [N_ENTRIES-1:0][KEY_W-1:0]  key_q;
  logic [N_ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [N_ENTRIES-1:0][PERM_W-1:0] perm_q;
  logic                             snp_done_q;

  // named internal events
  logic [KEY_W-1:0]     lk_key, fill_key, snp_key;
  logic [N_ENTRIES-1:0] lk_match, snp_match, fill_match;
  logic [N_ENTRIES-1:0] kill_vec;    // entries dropped by this cycle's snoop
  logic [N_ENTRIES-1:0] lk_hit_vec;  // live lookup hits after snoop masking
  logic [N_ENTRIES-1:0] wr_vec;      // slot written by this cycle's refill
  logic [N_ENTRIES-1:0] wr_set;      // written slot that ends up valid
  logic                 fill_cancel; // refill key equals snoop key
  logic [IDX_W-1:0]     fill_slot;
  fill_kind_e           fill_kind;

  function automatic logic [KEY_W-1:0] pack_key(input logic [ASID_W-1:0] a,
                                                input logic [VPN_W-1:0]  v);
    return {a, v};
  endfunction

  assign lk_key   = pack_key(lk_asid, lk_vpn);
  assign fill_key = pack_key(fill_asid, fill_vpn);
  assign snp_key  = pack_key(snp_asid, snp_vpn);

  stlb_match #(.N(N_ENTRIES), .KEY_W(KEY_W)) u_lk_cam (
    .valid(valid_q), .keys(key_q), .probe(lk_key), .hit(lk_match)
  );
  stlb_match #(.N(N_ENTRIES), .KEY_W(KEY_W)) u_snp_cam (
    .valid(valid_q), .keys(key_q), .probe(snp_key), .hit(snp_match)
  );
  stlb_match #(.N(N_ENTRIES), .KEY_W(KEY_W)) u_fill_cam (
    .valid(valid_q), .keys(key_q), .probe(fill_key), .hit(fill_match)
  );

  stlb_victim #(.N(N_ENTRIES)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_go  (fill_vld),
    .valid    (valid_q),
    .same_key (fill_match),
    .slot     (fill_slot),
    .kind     (fill_kind)
  );

  assign kill_vec    = snp_vld ? snp_match : '0;
  assign lk_hit_vec  = lk_vld ? (lk_match & ~kill_vec) : '0;
  assign fill_cancel = snp_vld && (fill_key == snp_key);
  assign wr_set      = fill_cancel ? '0 : wr_vec;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    assign wr_vec[g] = (fill_kind != FILL_NONE) && (fill_slot == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        key_q[g]   <= '0;
        ppn_q[g]   <= '0;
        perm_q[g]  <= '0;
      end else if (wr_vec[g]) begin
        valid_q[g] <= !fill_cancel;
        key_q[g]   <= fill_key;
        ppn_q[g]   <= fill_ppn;
        perm_q[g]  <= fill_perm;
      end else if (kill_vec[g]) begin
        valid_q[g] <= 1'b0;
      end
    end
  end

  // AND-OR read mux over the (at most one-hot) hit vector
  always_comb begin
    lk_ppn  = '0;
    lk_perm = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      lk_ppn  |= {PPN_W{lk_hit_vec[i]}} & ppn_q[i];
      lk_perm |= {PERM_W{lk_hit_vec[i]}} & perm_q[i];
    end
  end
  assign lk_hit = |lk_hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snp_done_q <= 1'b0;
    else        snp_done_q <= snp_vld;
  end
  assign snp_done = snp_done_q;
endmodule

// File: rtl/snoop_tlb_sva.sv
module snoop_tlb_sva #(
  parameter int N     = 16,
  parameter int KEY_W = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_vld,
  input logic             lk_hit,
  input logic             snp_vld,
  input logic             snp_done,
  input logic             fill_vld,
  input logic [KEY_W-1:0] lk_key,
  input logic [KEY_W-1:0] snp_key,
  input logic [KEY_W-1:0] fill_key,
  input logic [N-1:0]     valid_q,
  input logic [N-1:0]     kill_vec,
  input logic [N-1:0]     wr_vec,
  input logic [N-1:0]     wr_set,
  input logic [N-1:0]     lk_hit_vec
);
  p_done_after_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_vld |=> snp_done);

  p_done_only_after_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_vld |=> !snp_done);

  p_hit_needs_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_vld);

  p_single_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));

  p_kill_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|kill_vec) |=> ((valid_q & $past(kill_vec) & ~$past(wr_set)) == '0));

  p_race_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vld && snp_vld && fill_key == snp_key) |=> ((valid_q & $past(wr_vec)) == '0));

  p_lookup_race_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_vld && snp_vld && lk_key == snp_key) |-> !lk_hit);

  p_growth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_q) <= $countones($past(valid_q)) + 1);
endmodule

bind snoop_tlb snoop_tlb_sva #(.N(N_ENTRIES), .KEY_W(KEY_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_vld     (lk_vld),
  .lk_hit     (lk_hit),
  .snp_vld    (snp_vld),
  .snp_done   (snp_done),
  .fill_vld   (fill_vld),
  .lk_key     (lk_key),
  .snp_key    (snp_key),
  .fill_key   (fill_key),
  .valid_q    (valid_q),
  .kill_vec   (kill_vec),
  .wr_vec     (wr_vec),
  .wr_set     (wr_set),
  .lk_hit_vec (lk_hit_vec)
);

// File: tb/snoop_tlb_tb_top.sv
module snoop_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_vld;
  logic [19:0] lk_vpn;
  logic [7:0]  lk_asid;
  logic        lk_hit;
  logic [19:0] lk_ppn;
  logic [3:0]  lk_perm;
  logic        fill_vld;
  logic [19:0] fill_vpn;
  logic [7:0]  fill_asid;
  logic [19:0] fill_ppn;
  logic [3:0]  fill_perm;
  logic        snp_vld;
  logic [19:0] snp_vpn;
  logic [7:0]  snp_asid;
  logic        snp_done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  snoop_tlb dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_vld(lk_vld), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
    .fill_vld(fill_vld), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .snp_vld(snp_vld), .snp_vpn(snp_vpn), .snp_asid(snp_asid),
    .snp_done(snp_done)
  );

  // reference key set: key k -> vpn 0x100+k, ppn 0xA000+k, perm k[3:0]
  function automatic logic [19:0] kv(input int k);   return 20'h00100 + 20'(k); endfunction
  function automatic logic [19:0] kp(input int k);   return 20'h0A000 + 20'(k); endfunction
  function automatic logic [3:0]  kperm(input int k); return 4'(k); endfunction

  task automatic check(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    lk_vld = 0; lk_vpn = '0; lk_asid = '0;
    fill_vld = 0; fill_vpn = '0; fill_asid = '0; fill_ppn = '0; fill_perm = '0;
    snp_vld = 0; snp_vpn = '0; snp_asid = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] a, input logic [19:0] p,
                      input logic [3:0] pm);
    fill_vld = 1; fill_vpn = v; fill_asid = a; fill_ppn = p; fill_perm = pm;
    @(negedge clk);
    fill_vld = 0;
  endtask

  task automatic fill_key(input int k);
    fill(kv(k), 8'h03, kp(k), kperm(k));
  endtask

  task automatic snoop(input logic [19:0] v, input logic [7:0] a);
    snp_vld = 1; snp_vpn = v; snp_asid = a;
    @(negedge clk);
    snp_vld = 0;
  endtask

  // combinational lookup, sampled 1 ns after the falling edge
  task automatic look(input string req, input logic [19:0] v, input logic [7:0] a,
                      input logic eh, input logic [19:0] ep, input logic [3:0] epm);
    lk_vld = 1; lk_vpn = v; lk_asid = a;
    #1;
    check(req, "lk_hit", 32'(lk_hit), 32'(eh));
    check(req, "lk_ppn", 32'(lk_ppn), eh ? 32'(ep) : 32'h0);
    check(req, "lk_perm", 32'(lk_perm), eh ? 32'(epm) : 32'h0);
    lk_vld = 0;
    #1;
  endtask

  task automatic look_key(input string req, input int k, input logic eh);
    look(req, kv(k), 8'h03, eh, kp(k), kperm(k));
  endtask

  task automatic t_reset();
    do_reset();
    look_key("R1", 0, 0);
    look("R1", 20'h0, 8'h0, 0, 20'h0, 4'h0);
    check("R1", "snp_done", 32'(snp_done), 0);
  endtask

  task automatic t_basic();
    do_reset();
    fill_key(1);
    fill_key(2);
    look_key("R4", 1, 1);
    look_key("R2", 2, 1);
    look_key("R2", 7, 0);
    // lookup with lk_vld low reports nothing
    lk_vpn = kv(1); lk_asid = 8'h03; #1;
    check("R2", "lk_hit no request", 32'(lk_hit), 0);
    #1;
  endtask

  task automatic t_asid();
    do_reset();
    fill(20'h00555, 8'h11, 20'h12345, 4'h9);
    look("R3", 20'h00555, 8'h11, 1, 20'h12345, 4'h9);
    look("R3", 20'h00555, 8'h12, 0, 20'h0, 4'h0);
  endtask

  task automatic t_free_reuse();
    do_reset();
    for (int k = 0; k < 3; k++) fill_key(k);
    snoop(kv(1), 8'h03);
    for (int k = 3; k < 17; k++) fill_key(k);
    // 16 live keys: 0 and 2..16; none should have been evicted
    look_key("R4", 0, 1);
    for (int k = 2; k < 17; k++) look_key("R4", k, 1);
    look_key("R7", 1, 0);
  endtask

  task automatic t_round_robin();
    do_reset();
    for (int k = 0; k < 16; k++) fill_key(k);
    fill_key(100);
    look_key("R6", 0, 0);
    look_key("R6", 100, 1);
    for (int k = 1; k < 16; k++) look_key("R6", k, 1);
    fill_key(101);
    look_key("R6", 1, 0);
    // in-place update of key 100: no new slot, pointer unchanged
    fill(kv(100), 8'h03, 20'h0BEEF, 4'hE);
    look("R5", kv(100), 8'h03, 1, 20'h0BEEF, 4'hE);
    look_key("R5", 2, 1);
    fill_key(102);
    look_key("R6", 2, 0);
    look_key("R6", 3, 1);
    look("R5", kv(100), 8'h03, 1, 20'h0BEEF, 4'hE);
  endtask

  task automatic t_snoop_hit();
    do_reset();
    fill_key(4); fill_key(5); fill_key(6);
    snp_vld = 1; snp_vpn = kv(5); snp_asid = 8'h03;
    @(negedge clk);
    snp_vld = 0;
    check("R9", "snp_done after hit", 32'(snp_done), 1);
    look_key("R7", 5, 0);
    look_key("R7", 4, 1);
    look_key("R7", 6, 1);
    @(negedge clk);
    check("R9", "snp_done single", 32'(snp_done), 0);
  endtask

  task automatic t_snoop_miss();
    do_reset();
    fill_key(8); fill_key(9);
    snp_vld = 1; snp_vpn = kv(8); snp_asid = 8'h04;
    @(negedge clk);
    snp_vpn = kv(50); snp_asid = 8'h03;
    check("R9", "snp_done miss first", 32'(snp_done), 1);
    @(negedge clk);
    snp_vld = 0;
    check("R9", "snp_done back to back", 32'(snp_done), 1);
    look_key("R8", 8, 1);
    look_key("R8", 9, 1);
    @(negedge clk);
    check("R9", "snp_done ends", 32'(snp_done), 0);
  endtask

  task automatic t_race_fill();
    do_reset();
    // new key refilled and snooped together
    fill_vld = 1; fill_vpn = kv(20); fill_asid = 8'h03; fill_ppn = kp(20); fill_perm = 4'h1;
    snp_vld = 1; snp_vpn = kv(20); snp_asid = 8'h03;
    @(negedge clk);
    idle();
    look_key("R10", 20, 0);
    // already present key refilled and snooped together
    fill_key(21);
    fill_vld = 1; fill_vpn = kv(21); fill_asid = 8'h03; fill_ppn = 20'h0CCCC; fill_perm = 4'h2;
    snp_vld = 1; snp_vpn = kv(21); snp_asid = 8'h03;
    @(negedge clk);
    idle();
    look_key("R10", 21, 0);
  endtask

  task automatic t_race_lookup();
    do_reset();
    fill_key(30); fill_key(31);
    snp_vld = 1; snp_vpn = kv(30); snp_asid = 8'h03;
    look_key("R11", 30, 0);
    look_key("R11", 31, 1);
    @(negedge clk);
    snp_vld = 0;
    look_key("R7", 30, 0);
  endtask

  initial begin
    #(64'd200000 * 10);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    t_reset();
    t_basic();
    t_asid();
    t_free_reuse();
    t_round_robin();
    t_snoop_hit();
    t_snoop_miss();
    t_race_fill();
    t_race_lookup();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule